// File: doc/BRIEF.md
# Four-Valued Switch Network Stepper

This block evaluates a small network of n-type and p-type switches that meet at nodes. Every node carries a four-valued state, which is a subset of {L,H}. Some nodes are tied to a low or high source. When started, the block first resolves each node to the union of the sources it can reach through conducting switches. It then flips, in a single step, every switch whose conduction disagrees with a well-defined gate value. It repeats these two phases until nothing changes or a step budget runs out.

The switch table and the source ties are written one entry per cycle while the block is idle. A one-cycle `start` launches a run. `busy` stays high for the whole run. A one-cycle `done` pulse marks completion, and at that point the final node values, switch states, step count and diagnostic flags are held on the outputs. Switch conduction carries over from one run to the next unless it is rewritten. A later run therefore continues from the state the previous run left behind.

Top module: `swnet_stepper`

## Requirements
- R1: Each node value is two bits, bit 0 meaning "reaches L" and bit 1 meaning "reaches H": 2'b00 floating, 2'b01 low, 2'b10 high, 2'b11 conflicting. Node i occupies bits [2i+1:2i] of `node_val`, and source ties use the same code.
- R2: An enabled n-type switch (kind 0) wants to conduct when its gate is 2'b10 and to be off when its gate is 2'b01. A p-type switch (kind 1) wants the opposite.
- R3: After resolution, every node holds the OR of the source codes of all nodes reachable from it through enabled conducting switches, in either direction and over any number of hops.
- R4: In one step, all switches that disagree with a defined gate flip together, and `steps` grows by exactly one.
- R5: An enabled switch whose gate is 2'b00 or 2'b11 keeps its conduction state, and its bit in `undef_gate` is set at completion. Disabled switches never conduct and are never flagged.
- R6: Bit i of `conflict` is set if node i resolved to 2'b11 at any point during the run, including intermediate states.
- R7: When no switch disagrees with a defined gate, the run ends with a `done` pulse, `osc` low, and `steps` equal to the number of update steps applied.
- R8: If switches still disagree after `step_limit` steps, the run stops with `osc` high and `steps` equal to `step_limit`. The outputs then show the last resolved nodes.
- R9: Switch and source writes presented while `busy` is high have no effect.
- R10: After reset, `busy`, `done`, `osc`, `node_val`, `sw_on`, `conflict` and `undef_gate` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one switch entry |
| cfg_idx | input | 3 | Switch index |
| cfg_en | input | 1 | Switch present |
| cfg_kind | input | 1 | 0 n-type, 1 p-type |
| cfg_gate | input | 3 | Gate node |
| cfg_pa | input | 3 | First pass node |
| cfg_pb | input | 3 | Second pass node |
| cfg_on | input | 1 | Initial conduction |
| src_we | input | 1 | Write one source tie |
| src_idx | input | 3 | Node index |
| src_val | input | 2 | Source code (R1) |
| step_limit | input | 8 | Step budget, captured at start |
| start | input | 1 | Launch a run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| steps | output | 8 | Update steps applied |
| osc | output | 1 | Budget exhausted without settling |
| node_val | output | 16 | Resolved node values |
| sw_on | output | 8 | Switch conduction states |
| conflict | output | 8 | Nodes seen conflicting during the run |
| undef_gate | output | 8 | Switches with undefined gates |

## Verification
A CMOS inverter is driven from both input levels. This separates the n-type and p-type gate rules and shows that two switches flip in the same step. A pair of switches fighting over one node shows that a conflict spreads across several hops and that a stable state can still contain it. A long chain of conducting switches tells a full closure apart from a single neighbour pass. A switch whose gate node floats, tried from both initial states, shows that its state is held and its flag is raised. A self-toggling pull pair is run with a zero budget, a small budget and a larger budget. These runs pin the oscillation stop and the step count, and the larger run also shows that writes made mid-run are ignored.

// File: rtl/swnet_pkg.sv
package swnet_pkg;
  typedef logic [1:0] nval_t;
  localparam nval_t NV_FLOAT = 2'b00;
  localparam nval_t NV_LOW   = 2'b01;
  localparam nval_t NV_HIGH  = 2'b10;
  localparam nval_t NV_CONF  = 2'b11;
  localparam logic  KIND_N   = 1'b0;
  localparam logic  KIND_P   = 1'b1;
  typedef enum logic [1:0] {ST_IDLE, ST_RESOLVE, ST_REACT} st_t;
endpackage

// File: rtl/swnet_resolve.sv
module swnet_resolve #(
  parameter int NODES    = 8,
  parameter int SWITCHES = 8,
  parameter int NW       = 3
) (
  input  logic [2*NODES-1:0]     cur_val,
  input  logic [SWITCHES-1:0]    sw_on,
  input  logic [SWITCHES-1:0]    sw_en,
  input  logic [SWITCHES*NW-1:0] pa_flat,
  input  logic [SWITCHES*NW-1:0] pb_flat,
  output logic [2*NODES-1:0]     nxt_val
);
  // One neighbour-propagation pass over all conducting switches.
  always_comb begin
    nxt_val = cur_val;
    for (int s = 0; s < SWITCHES; s++) begin
      if (sw_en[s] && sw_on[s]) begin
        nxt_val[2*int'(pb_flat[s*NW +: NW]) +: 2] =
          nxt_val[2*int'(pb_flat[s*NW +: NW]) +: 2] | cur_val[2*int'(pa_flat[s*NW +: NW]) +: 2];
        nxt_val[2*int'(pa_flat[s*NW +: NW]) +: 2] =
          nxt_val[2*int'(pa_flat[s*NW +: NW]) +: 2] | cur_val[2*int'(pb_flat[s*NW +: NW]) +: 2];
      end
    end
  end
endmodule

// File: rtl/swnet_react.sv
module swnet_react
  import swnet_pkg::*;
#(
  parameter int NODES    = 8,
  parameter int SWITCHES = 8,
  parameter int NW       = 3
) (
  input  logic [2*NODES-1:0]     vals,
  input  logic [SWITCHES-1:0]    sw_on,
  input  logic [SWITCHES-1:0]    sw_en,
  input  logic [SWITCHES-1:0]    sw_kind,
  input  logic [SWITCHES*NW-1:0] gate_flat,
  output logic [SWITCHES-1:0]    flip,
  output logic [SWITCHES-1:0]    undef
);
  for (genvar s = 0; s < SWITCHES; s++) begin : g_sw
    nval_t g;
    logic  defined, want;
    always_comb begin
      g       = vals[2*int'(gate_flat[s*NW +: NW]) +: 2];
      defined = (g == NV_LOW) || (g == NV_HIGH);
      want    = (sw_kind[s] == KIND_P) ? (g == NV_LOW) : (g == NV_HIGH);
      flip[s]  = sw_en[s] && defined && (want != sw_on[s]);
      undef[s] = sw_en[s] && !defined;
    end
  end
endmodule

// File: rtl/swnet_stepper.sv
module swnet_stepper
  import swnet_pkg::*;
#(
  parameter int NODES    = 8,
  parameter int SWITCHES = 8,
  parameter int STEP_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [$clog2(SWITCHES)-1:0]  cfg_idx,
  input  logic                         cfg_en,
  input  logic                         cfg_kind,
  input  logic [$clog2(NODES)-1:0]     cfg_gate,
  input  logic [$clog2(NODES)-1:0]     cfg_pa,
  input  logic [$clog2(NODES)-1:0]     cfg_pb,
  input  logic                         cfg_on,
  input  logic                         src_we,
  input  logic [$clog2(NODES)-1:0]     src_idx,
  input  logic [1:0]                   src_val,
  input  logic [STEP_W-1:0]            step_limit,
  input  logic                         start,
  output logic                         busy,
  output logic                         done,
  output logic [STEP_W-1:0]            steps,
  output logic                         osc,
  output logic [2*NODES-1:0]           node_val,
  output logic [SWITCHES-1:0]          sw_on,
  output logic [NODES-1:0]             conflict,
  output logic [SWITCHES-1:0]          undef_gate
);
  localparam int NW = $clog2(NODES);
  localparam int PW = $clog2(NODES + 1);
  localparam logic [PW-1:0] PASS_LIM = PW'(NODES - 1);

  st_t                    st_q;
  logic [SWITCHES-1:0]    en_q, kind_q, on_q;
  logic [SWITCHES*NW-1:0] gate_q, pa_q, pb_q;
  logic [2*NODES-1:0]     src_q, vals_q, nxt_val;
  logic [PW-1:0]          pass_q;
  logic [STEP_W-1:0]      steps_q, lim_q;
  logic                   osc_q, done_q;
  logic [NODES-1:0]       conf_q, conf_now;
  logic [SWITCHES-1:0]    undef_q, undef_now, flip_now;

  swnet_resolve #(.NODES(NODES), .SWITCHES(SWITCHES), .NW(NW)) u_resolve (
    .cur_val(vals_q), .sw_on(on_q), .sw_en(en_q),
    .pa_flat(pa_q), .pb_flat(pb_q), .nxt_val(nxt_val)
  );

  swnet_react #(.NODES(NODES), .SWITCHES(SWITCHES), .NW(NW)) u_react (
    .vals(vals_q), .sw_on(on_q), .sw_en(en_q), .sw_kind(kind_q),
    .gate_flat(gate_q), .flip(flip_now), .undef(undef_now)
  );

  always_comb begin
    for (int i = 0; i < NODES; i++) conf_now[i] = &vals_q[2*i +: 2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      en_q    <= '0;
      kind_q  <= '0;
      on_q    <= '0;
      gate_q  <= '0;
      pa_q    <= '0;
      pb_q    <= '0;
      src_q   <= '0;
      vals_q  <= '0;
      pass_q  <= '0;
      steps_q <= '0;
      lim_q   <= '0;
      osc_q   <= 1'b0;
      done_q  <= 1'b0;
      conf_q  <= '0;
      undef_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cfg_we) begin
            en_q[cfg_idx]              <= cfg_en;
            kind_q[cfg_idx]            <= cfg_kind;
            on_q[cfg_idx]              <= cfg_on & cfg_en;
            gate_q[cfg_idx*NW +: NW]   <= cfg_gate;
            pa_q[cfg_idx*NW +: NW]     <= cfg_pa;
            pb_q[cfg_idx*NW +: NW]     <= cfg_pb;
          end
          if (src_we) src_q[2*src_idx +: 2] <= src_val;
          if (start) begin
            vals_q  <= src_q;
            pass_q  <= '0;
            steps_q <= '0;
            lim_q   <= step_limit;
            osc_q   <= 1'b0;
            conf_q  <= '0;
            undef_q <= '0;
            st_q    <= ST_RESOLVE;
          end
        end
        ST_RESOLVE: begin
          vals_q <= nxt_val;
          pass_q <= pass_q + 1'b1;
          if (nxt_val == vals_q || pass_q == PASS_LIM) st_q <= ST_REACT;
        end
        ST_REACT: begin
          conf_q  <= conf_q | conf_now;
          undef_q <= undef_now;
          if (flip_now == '0) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (steps_q == lim_q) begin
            osc_q  <= 1'b1;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            on_q    <= on_q ^ flip_now;
            steps_q <= steps_q + 1'b1;
            vals_q  <= src_q;
            pass_q  <= '0;
            st_q    <= ST_RESOLVE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign steps      = steps_q;
  assign osc        = osc_q;
  assign node_val   = vals_q;
  assign sw_on      = on_q;
  assign conflict   = conf_q;
  assign undef_gate = undef_q;

  // Pass-node agreement once resolution has finished.
  logic [SWITCHES-1:0] pass_eq;
  always_comb begin
    for (int s = 0; s < SWITCHES; s++)
      pass_eq[s] = vals_q[2*int'(pa_q[s*NW +: NW]) +: 2] == vals_q[2*int'(pb_q[s*NW +: NW]) +: 2];
  end

  for (genvar s = 0; s < SWITCHES; s++) begin : g_chk
    p_closure_agree_r3: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_REACT && en_q[s] && on_q[s]) |-> pass_eq[s]);
    p_undef_holds_r5: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_REACT && undef_now[s]) |=> $stable(on_q[s]));
  end

  p_done_from_react_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(st_q) == ST_REACT);
  p_steps_within_budget_r8: assert property (@(posedge clk) disable iff (rst)
    steps_q <= lim_q);
  p_osc_ends_run_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_q) |-> (done_q && st_q == ST_IDLE));
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> ($stable(gate_q) && $stable(pa_q) && $stable(pb_q) &&
                           $stable(en_q) && $stable(src_q)));
endmodule

// File: tb/swnet_stepper_bench.sv
module swnet_stepper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_en = 0, cfg_kind = 0, cfg_on = 0;
  logic [2:0] cfg_idx = 0, cfg_gate = 0, cfg_pa = 0, cfg_pb = 0;
  logic src_we = 0;
  logic [2:0] src_idx = 0;
  logic [1:0] src_val = 0;
  logic [7:0] step_limit = 0;
  logic start = 0;
  logic busy, done, osc;
  logic [7:0] steps, sw_on, conflict, undef_gate;
  logic [15:0] node_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  swnet_stepper u_swnet_stepper (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_kind(cfg_kind), .cfg_gate(cfg_gate), .cfg_pa(cfg_pa), .cfg_pb(cfg_pb),
    .cfg_on(cfg_on), .src_we(src_we), .src_idx(src_idx), .src_val(src_val),
    .step_limit(step_limit), .start(start), .busy(busy), .done(done),
    .steps(steps), .osc(osc), .node_val(node_val), .sw_on(sw_on),
    .conflict(conflict), .undef_gate(undef_gate)
  );

  typedef struct {
    logic [15:0] nv;
    logic [7:0]  on;
    logic [7:0]  st;
    logic        osc;
    logic [7:0]  conf;
    logic [7:0]  und;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor: compares each completion against the head of the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (sb.size() == 0) begin
          chk(0, "R7", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(node_val == e.nv, e.tag, "node_val", 32'(node_val), 32'(e.nv));
          chk(sw_on == e.on, e.tag, "sw_on", 32'(sw_on), 32'(e.on));
          chk(steps == e.st, e.tag, "steps", 32'(steps), 32'(e.st));
          chk(osc == e.osc, e.tag, "osc", 32'(osc), 32'(e.osc));
          chk(conflict == e.conf, e.tag, "conflict", 32'(conflict), 32'(e.conf));
          chk(undef_gate == e.und, e.tag, "undef_gate", 32'(undef_gate), 32'(e.und));
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(0, "R7", "watchdog expired", 0, 1);
    summary();
  end

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic wr_sw(input int idx, input bit en, input bit kind, input int g,
                       input int a, input int b, input bit on);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_en = en; cfg_kind = kind;
    cfg_gate = 3'(g); cfg_pa = 3'(a); cfg_pb = 3'(b); cfg_on = on;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_src(input int idx, input logic [1:0] v);
    @(negedge clk);
    src_we = 1; src_idx = 3'(idx); src_val = v;
    @(negedge clk); src_we = 0;
  endtask

  // Driver: pushes the expected result, then launches the run.
  task automatic launch(input logic [7:0] lim, input logic [15:0] nv, input logic [7:0] on,
                        input logic [7:0] st, input logic os, input logic [7:0] cf,
                        input logic [7:0] un, input string tag);
    exp_t e;
    e.nv = nv; e.on = on; e.st = st; e.osc = os; e.conf = cf; e.und = un; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    step_limit = lim; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R10: reset state
    chk(busy == 0, "R10", "busy", 32'(busy), 0);
    chk(done == 0, "R10", "done", 32'(done), 0);
    chk(osc == 0, "R10", "osc", 32'(osc), 0);
    chk(node_val == 0, "R10", "node_val", 32'(node_val), 0);
    chk(sw_on == 0, "R10", "sw_on", 32'(sw_on), 0);
    chk(conflict == 0 && undef_gate == 0, "R10", "flags", 32'({conflict, undef_gate}), 0);

    // Inverter: n0 input, n1 high rail, n2 low rail, n3 output.
    wr_src(0, 2'b10); wr_src(1, 2'b10); wr_src(2, 2'b01);
    wr_sw(0, 1, 1, 0, 1, 3, 0);   // p-type
    wr_sw(1, 1, 0, 0, 2, 3, 0);   // n-type
    launch(8'd10, 16'h005A, 8'h02, 8'd1, 0, 8'h00, 8'h00, "R1/R2 inverter input high");
    drain();
    wr_src(0, 2'b01);
    launch(8'd10, 16'h0099, 8'h01, 8'd1, 0, 8'h00, 8'h00, "R2/R4 inverter input low");
    drain();

    // Fighting pair: n-type now gated by n4 (high), p gated by n0 (low).
    wr_src(4, 2'b10);
    wr_sw(1, 1, 0, 4, 2, 3, 0);
    launch(8'd10, 16'h02FD, 8'h03, 8'd1, 0, 8'h0E, 8'h00, "R3/R6 static conflict");
    drain();

    // Floating gate held on and held off.
    do_reset();
    wr_src(6, 2'b10);
    wr_sw(0, 1, 0, 5, 6, 7, 1);
    launch(8'd10, 16'hA000, 8'h01, 8'd0, 0, 8'h00, 8'h01, "R5 undefined gate held on");
    drain();
    wr_sw(0, 1, 0, 5, 6, 7, 0);
    launch(8'd10, 16'h2000, 8'h00, 8'd0, 0, 8'h00, 8'h01, "R5 undefined gate held off");
    drain();

    // Self-toggling pull pair on n1.
    do_reset();
    wr_src(0, 2'b01); wr_src(2, 2'b10);
    wr_sw(0, 1, 0, 1, 0, 1, 0);
    wr_sw(1, 1, 1, 1, 2, 1, 1);
    launch(8'd5, 16'h0025, 8'h01, 8'd5, 1, 8'h00, 8'h00, "R8 oscillation budget 5");
    drain();
    wr_sw(0, 1, 0, 1, 0, 1, 0);
    wr_sw(1, 1, 1, 1, 2, 1, 1);
    launch(8'd0, 16'h0029, 8'h02, 8'd0, 1, 8'h00, 8'h00, "R8 zero budget");
    drain();

    // R9: write during the run must not take effect.
    launch(8'd20, 16'h0029, 8'h02, 8'd20, 1, 8'h00, 8'h00, "R9 write while busy");
    repeat (3) @(negedge clk);
    chk(busy == 1, "R9", "busy during run", 32'(busy), 1);
    cfg_we = 1; cfg_idx = 0; cfg_en = 0; cfg_kind = 0; cfg_gate = 0; cfg_pa = 0; cfg_pb = 0; cfg_on = 0;
    src_we = 1; src_idx = 2; src_val = 2'b01;
    @(negedge clk); cfg_we = 0; src_we = 0;
    drain();

    // Long chain: needs a multi-pass closure.
    do_reset();
    wr_src(0, 2'b10); wr_src(7, 2'b10);
    for (int i = 0; i < 4; i++) wr_sw(i, 1, 0, 7, i, i + 1, 1);
    launch(8'd10, 16'h82AA, 8'h0F, 8'd0, 0, 8'h00, 8'h00, "R3/R7 four-hop chain");
    drain();

    repeat (3) @(negedge clk);
    summary();
  end
endmodule